// File: doc/BRIEF.md
# Power-Down Mode Controller

This block steps a processor subsystem through its low-power states and back. A one-cycle sleep strobe, qualified by two standby-control bits, moves it from run into one of three depths. In light sleep only the CPU clock stops. In software standby the clock generator and every peripheral clock stop too, and external memory goes to self-refresh. In deep standby the core power supply is also switched off, and selected RAM banks are held in retention.

Each depth accepts its own set of wake sources. A wake brings the enables back in the reverse order of shutdown: core power, then the clock generator with a fixed settle window, then the CPU and peripheral clocks. A one-cycle done pulse marks the return to run. The block also holds a per-module stop register that gates individual peripheral clocks, and it passes the real-time clock enable through in every mode. A flag tells the CPU whether the wake must be handled as a reset or as an interrupt.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After rst_ni the block is in run: mode_o=0, CPU clock, clock generator and core power enabled, all peripheral clocks enabled, self_refresh_o=0, ram_ret_o=0, wake_rst_o=0, wake_done_o=0.
- R2: A sleep strobe with stby_i=0 enters light sleep on the next edge: mode_o=1, cpu_clk_en_o=0, and the clock generator, core power and unstopped peripheral clocks stay on, with self_refresh_o=0.
- R3: A sleep strobe with stby_i=1 and deep_i=0 enters software standby: mode_o=2, cpu_clk_en_o, cpg_en_o and all per_clk_en_o bits are 0, core_pwr_en_o=1 and self_refresh_o=1.
- R4: A sleep strobe with stby_i=1 and deep_i=1 enters deep standby: mode_o=3, core_pwr_en_o=0, all clocks off and self_refresh_o=1.
- R5: Light sleep wakes on int_req_i, bus_err_i, nmi_i, any irq_i bit, mrst_i or por_i. wake_rst_o is then 1 only if mrst_i or por_i caused the wake.
- R6: Software standby wakes only on nmi_i, any irq_i bit, mrst_i or por_i. int_req_i and bus_err_i leave it in mode 2.
- R7: Deep standby wakes only on nmi_i, mrst_i, por_i or an irq_i bit set in DEEP_IRQ_MASK (default bits 3..0). Any deep wake sets wake_rst_o=1.
- R8: On entry to deep standby, ram_keep_i is captured into ram_ret_o. ram_ret_o holds that value through deep standby and the wake steps, and returns to 0 in run. A wake by por_i clears it from the first wake cycle.
- R9: A deep wake gives one cycle with only core power on. A standby wake, or the step after that power cycle, gives SETTLE_CYC cycles with the clock generator on and the CPU and peripheral clocks off, with self-refresh held. Next comes one cycle with the CPU and peripheral clocks on and wake_done_o=1, then run. A light-sleep wake goes straight to that final cycle.
- R10: mstop_we_i loads mstop_d_i into the stop register. per_clk_en_o[i] is 0 from the next cycle while bit i is set, in run and in light sleep, and writing the bit back to 0 resumes the clock.
- R11: por_i clears the stop bits selected by POR_CLR_MASK (default bits 3..0) and leaves the others. If it coincides with a write, the written value is used with those bits forced to 0.
- R12: rtc_en_o equals rtc_start_i in every mode, including deep standby.
- R13: A sleep strobe is ignored, and the block stays in run with all enables unchanged, when a wake source of the depth it selects is active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Sleep instruction strobe |
| stby_i | input | 1 | Standby-select control bit |
| deep_i | input | 1 | Deep-select control bit |
| ram_keep_i | input | NBANK | Per-bank retention select |
| mstop_we_i | input | 1 | Stop register write enable |
| mstop_d_i | input | NMOD | Stop register write data |
| rtc_start_i | input | 1 | Real-time clock start bit |
| int_req_i | input | 1 | Enabled maskable interrupt pending |
| nmi_i | input | 1 | Non-maskable interrupt |
| irq_i | input | NIRQ | External interrupt request lines |
| bus_err_i | input | 1 | Bus error event |
| mrst_i | input | 1 | Manual reset event |
| por_i | input | 1 | Power-on reset event |
| mode_o | output | 2 | 0 run or wake, 1 sleep, 2 software standby, 3 deep standby |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| cpg_en_o | output | 1 | Clock generator enable |
| per_clk_en_o | output | NMOD | Per-module peripheral clock enables |
| core_pwr_en_o | output | 1 | Core power supply enable |
| ram_ret_o | output | NBANK | Per-bank RAM retention enables |
| rtc_en_o | output | 1 | Real-time clock enable |
| self_refresh_o | output | 1 | External memory refresh mode, 1 self, 0 auto |
| wake_rst_o | output | 1 | Wake must use reset exception handling |
| wake_done_o | output | 1 | One-cycle pulse at the end of a wake |

## Verification
Two pairs of events can land on the same edge. The first pair is a sleep strobe and an active wake source of the selected depth. The bench raises both in one cycle and expects run to hold with all enables on. It also raises a strobe together with an IRQ line outside the deep mask and expects deep entry. The second pair is a stop-register write and a power-on reset. The bench drives both together and expects the written value with the reset-cleared bits forced to zero, as seen on the peripheral clock enables.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_SLP  = 3'd1,
    ST_SSB  = 3'd2,
    ST_DSB  = 3'd3,
    ST_WPWR = 3'd4,
    ST_WCPG = 3'd5,
    ST_WCLK = 3'd6
  } pmc_state_e;

  localparam logic [1:0] MODE_RUN = 2'd0;
  localparam logic [1:0] MODE_SLP = 2'd1;
  localparam logic [1:0] MODE_SSB = 2'd2;
  localparam logic [1:0] MODE_DSB = 2'd3;
endpackage

// File: rtl/pmc_wake_filt.sv
module pmc_wake_filt #(
  parameter int              NIRQ          = 8,
  parameter logic [NIRQ-1:0] DEEP_IRQ_MASK = 8'h0F
) (
  input  logic            int_req_i,
  input  logic            nmi_i,
  input  logic [NIRQ-1:0] irq_i,
  input  logic            bus_err_i,
  input  logic            mrst_i,
  input  logic            por_i,
  output logic            wk_slp_o,
  output logic            wk_ssb_o,
  output logic            wk_dsb_o,
  output logic            rst_cause_o
);
  logic any_irq, deep_irq;

  assign any_irq     = |irq_i;
  assign deep_irq    = |(irq_i & DEEP_IRQ_MASK);
  assign rst_cause_o = mrst_i | por_i;
  assign wk_slp_o    = int_req_i | bus_err_i | nmi_i | any_irq | rst_cause_o;
  assign wk_ssb_o    = nmi_i | any_irq | rst_cause_o;
  assign wk_dsb_o    = nmi_i | deep_irq | rst_cause_o;
endmodule

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
#(
  parameter int SETTLE_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_i,
  input  logic       stby_i,
  input  logic       deep_i,
  input  logic       wk_slp_i,
  input  logic       wk_ssb_i,
  input  logic       wk_dsb_i,
  input  logic       rst_cause_i,
  input  logic       por_i,
  output pmc_state_e state_o,
  output logic       wake_rst_o,
  output logic       ld_ret_o,
  output logic       clr_ret_o
);
  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE_CYC - 1);

  pmc_state_e st_q, st_d, target;
  logic [CW-1:0] cnt_q, cnt_d;
  logic wrst_q, wrst_d, pend;

  always_comb begin
    if (!stby_i)      target = ST_SLP;
    else if (!deep_i) target = ST_SSB;
    else              target = ST_DSB;
    case (target)
      ST_SLP:  pend = wk_slp_i;
      ST_SSB:  pend = wk_ssb_i;
      default: pend = wk_dsb_i;
    endcase
  end

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    wrst_d    = wrst_q;
    ld_ret_o  = 1'b0;
    clr_ret_o = 1'b0;
    case (st_q)
      ST_RUN: if (sleep_i && !pend) begin
        st_d     = target;
        wrst_d   = 1'b0;
        ld_ret_o = (target == ST_DSB);
      end
      ST_SLP: if (wk_slp_i) begin
        st_d   = ST_WCLK;
        wrst_d = rst_cause_i;
      end
      ST_SSB: if (wk_ssb_i) begin
        st_d   = ST_WCPG;
        cnt_d  = CNT_LOAD;
        wrst_d = rst_cause_i;
      end
      ST_DSB: if (wk_dsb_i) begin
        st_d      = ST_WPWR;
        wrst_d    = 1'b1;
        clr_ret_o = por_i;
      end
      ST_WPWR: begin
        st_d  = ST_WCPG;
        cnt_d = CNT_LOAD;
      end
      ST_WCPG: begin
        if (cnt_q == '0) st_d = ST_WCLK;
        else             cnt_d = cnt_q - 1'b1;
      end
      ST_WCLK: begin
        st_d      = ST_RUN;
        clr_ret_o = 1'b1;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_RUN;
      cnt_q  <= '0;
      wrst_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      wrst_q <= wrst_d;
    end
  end

  assign state_o    = st_q;
  assign wake_rst_o = wrst_q;

  assert_pend_ignore_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN && sleep_i && !stby_i && wk_slp_i) |=> st_q == ST_RUN);
  assert_ssb_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SSB && !wk_ssb_i) |=> st_q == ST_SSB);
  assert_deep_wake_pwr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DSB && wk_dsb_i) |=> st_q == ST_WPWR);
  assert_wclk_origin_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_q == ST_WCLK) |-> ($past(st_q) == ST_WCPG || $past(st_q) == ST_SLP));
  assert_deep_wake_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DSB && wk_dsb_i) |=> wrst_q);
endmodule

// File: rtl/pmc_mstop.sv
module pmc_mstop #(
  parameter int              NMOD         = 8,
  parameter logic [NMOD-1:0] POR_CLR_MASK = 8'h0F
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [NMOD-1:0] d_i,
  input  logic            por_i,
  output logic [NMOD-1:0] stop_o
);
  logic [NMOD-1:0] stop_q;

  for (genvar i = 0; i < NMOD; i++) begin : g_bit
    if (POR_CLR_MASK[i]) begin : g_por
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    stop_q[i] <= 1'b0;
        else if (por_i) stop_q[i] <= 1'b0;
        else if (we_i)  stop_q[i] <= d_i[i];
      end
    end else begin : g_keep
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   stop_q[i] <= 1'b0;
        else if (we_i) stop_q[i] <= d_i[i];
      end
    end
  end

  assign stop_o = stop_q;

  assert_por_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (stop_q & POR_CLR_MASK) == '0);
  assert_stop_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && !por_i) |=> $stable(stop_q));
endmodule

// File: rtl/pmc_ram_ret.sv
module pmc_ram_ret #(
  parameter int NBANK = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic             clr_i,
  input  logic [NBANK-1:0] keep_i,
  output logic [NBANK-1:0] ret_o
);
  logic [NBANK-1:0] ret_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    ret_q[b] <= 1'b0;
      else if (clr_i) ret_q[b] <= 1'b0;
      else if (ld_i)  ret_q[b] <= keep_i[b];
    end
  end

  assign ret_o = ret_q;

  assert_ret_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_i && !clr_i) |=> ret_q == $past(keep_i));
  assert_ret_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ret_q == '0);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int               NMOD          = 8,
  parameter int               NBANK         = 4,
  parameter int               NIRQ          = 8,
  parameter int               SETTLE_CYC    = 4,
  parameter logic [NIRQ-1:0]  DEEP_IRQ_MASK = 8'h0F,
  parameter logic [NMOD-1:0]  POR_CLR_MASK  = 8'h0F
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic             stby_i,
  input  logic             deep_i,
  input  logic [NBANK-1:0] ram_keep_i,
  input  logic             mstop_we_i,
  input  logic [NMOD-1:0]  mstop_d_i,
  input  logic             rtc_start_i,
  input  logic             int_req_i,
  input  logic             nmi_i,
  input  logic [NIRQ-1:0]  irq_i,
  input  logic             bus_err_i,
  input  logic             mrst_i,
  input  logic             por_i,
  output logic [1:0]       mode_o,
  output logic             cpu_clk_en_o,
  output logic             cpg_en_o,
  output logic [NMOD-1:0]  per_clk_en_o,
  output logic             core_pwr_en_o,
  output logic [NBANK-1:0] ram_ret_o,
  output logic             rtc_en_o,
  output logic             self_refresh_o,
  output logic             wake_rst_o,
  output logic             wake_done_o
);
  pmc_state_e      state;
  logic            wk_slp, wk_ssb, wk_dsb, rst_cause, ld_ret, clr_ret, per_on;
  logic [NMOD-1:0] stop;

  pmc_wake_filt #(.NIRQ(NIRQ), .DEEP_IRQ_MASK(DEEP_IRQ_MASK)) u_filt (
    .int_req_i(int_req_i), .nmi_i(nmi_i), .irq_i(irq_i), .bus_err_i(bus_err_i),
    .mrst_i(mrst_i), .por_i(por_i), .wk_slp_o(wk_slp), .wk_ssb_o(wk_ssb),
    .wk_dsb_o(wk_dsb), .rst_cause_o(rst_cause)
  );

  pmc_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_i(sleep_i), .stby_i(stby_i),
    .deep_i(deep_i), .wk_slp_i(wk_slp), .wk_ssb_i(wk_ssb), .wk_dsb_i(wk_dsb),
    .rst_cause_i(rst_cause), .por_i(por_i), .state_o(state),
    .wake_rst_o(wake_rst_o), .ld_ret_o(ld_ret), .clr_ret_o(clr_ret)
  );

  pmc_mstop #(.NMOD(NMOD), .POR_CLR_MASK(POR_CLR_MASK)) u_mstop (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(mstop_we_i), .d_i(mstop_d_i),
    .por_i(por_i), .stop_o(stop)
  );

  pmc_ram_ret #(.NBANK(NBANK)) u_ret (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld_ret), .clr_i(clr_ret),
    .keep_i(ram_keep_i), .ret_o(ram_ret_o)
  );

  always_comb begin
    mode_o         = MODE_RUN;
    cpu_clk_en_o   = 1'b0;
    cpg_en_o       = 1'b1;
    per_on         = 1'b0;
    core_pwr_en_o  = 1'b1;
    self_refresh_o = 1'b0;
    wake_done_o    = 1'b0;
    case (state)
      ST_RUN: begin
        cpu_clk_en_o = 1'b1;
        per_on       = 1'b1;
      end
      ST_SLP: begin
        mode_o = MODE_SLP;
        per_on = 1'b1;
      end
      ST_SSB: begin
        mode_o         = MODE_SSB;
        cpg_en_o       = 1'b0;
        self_refresh_o = 1'b1;
      end
      ST_DSB: begin
        mode_o         = MODE_DSB;
        cpg_en_o       = 1'b0;
        core_pwr_en_o  = 1'b0;
        self_refresh_o = 1'b1;
      end
      ST_WPWR: begin
        cpg_en_o       = 1'b0;
        self_refresh_o = 1'b1;
      end
      ST_WCPG: self_refresh_o = 1'b1;
      ST_WCLK: begin
        cpu_clk_en_o = 1'b1;
        per_on       = 1'b1;
        wake_done_o  = 1'b1;
      end
      default: ;
    endcase
  end

  assign per_clk_en_o = per_on ? ~stop : '0;
  assign rtc_en_o     = rtc_start_i;

  assert_pwr_off_deep_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_pwr_en_o |-> mode_o == MODE_DSB);
  assert_cpu_needs_cpg_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_clk_en_o |-> (cpg_en_o && core_pwr_en_o));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_done_o |=> !wake_done_o);
  assert_selfref_cpg_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpg_en_o |-> self_refresh_o);
  assert_ret_idle_run_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && !wake_done_o) |-> ram_ret_o == '0);
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sleep = 0, stby = 0, deep = 0, mwe = 0, rtc = 0;
  logic [3:0] keep = '0;
  logic [7:0] md = '0, irq = '0;
  logic       intr = 0, nmi = 0, berr = 0, mrst = 0, por = 0;
  logic [1:0] mode;
  logic       cpu_en, cpg_en, pwr_en, rtc_en, sref, wrst, done;
  logic [7:0] per_en;
  logic [3:0] ret;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep), .stby_i(stby), .deep_i(deep),
    .ram_keep_i(keep), .mstop_we_i(mwe), .mstop_d_i(md), .rtc_start_i(rtc),
    .int_req_i(intr), .nmi_i(nmi), .irq_i(irq), .bus_err_i(berr), .mrst_i(mrst),
    .por_i(por), .mode_o(mode), .cpu_clk_en_o(cpu_en), .cpg_en_o(cpg_en),
    .per_clk_en_o(per_en), .core_pwr_en_o(pwr_en), .ram_ret_o(ret),
    .rtc_en_o(rtc_en), .self_refresh_o(sref), .wake_rst_o(wrst), .wake_done_o(done)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic enter(logic s, logic d);
    stby = s; deep = d; sleep = 1'b1;
    tick();
    sleep = 1'b0;
  endtask

  // enables packed as {cpu,cpg,pwr,sref}
  function automatic int en4();
    return {cpu_en, cpg_en, pwr_en, sref};
  endfunction

  task automatic t_reset;
    chk("R1 mode", mode, 0);
    chk("R1 enables", en4(), 4'b1110);
    chk("R1 per", per_en, 8'hFF);
    chk("R1 ret/flags", {ret, wrst, done}, 0);
  endtask

  task automatic t_sleep;
    enter(1'b0, 1'b0);
    chk("R2 mode", mode, 1);
    chk("R2 enables", en4(), 4'b0110);
    chk("R2 per", per_en, 8'hFF);
    berr = 1'b1; tick(); berr = 1'b0;
    chk("R5 bus err wake final step", {cpu_en, done, wrst}, 3'b110);
    tick();
    chk("R9 back to run", {mode, done}, 0);
    enter(1'b0, 1'b0);
    mrst = 1'b1; tick(); mrst = 1'b0;
    chk("R5 manual reset flag", {done, wrst}, 2'b11);
    tick();
  endtask

  task automatic t_sstby;
    enter(1'b1, 1'b0);
    chk("R3 mode", mode, 2);
    chk("R3 enables", en4(), 4'b0011);
    chk("R3 per", per_en, 0);
    intr = 1'b1; berr = 1'b1; tick(); intr = 1'b0; berr = 1'b0;
    chk("R6 int/buserr ignored", mode, 2);
    nmi = 1'b1; tick(); nmi = 1'b0;
    chk("R9 standby settle start", en4(), 4'b0111);
    tick(3);
    chk("R9 settle still", {en4(), per_en}, {4'b0111, 8'h00});
    tick();
    chk("R9 clock step", {cpu_en, done, per_en}, {2'b11, 8'hFF});
    chk("R6 nmi flag", wrst, 0);
    tick();
    chk("R9 run", {mode, done}, 0);
  endtask

  task automatic t_deep;
    keep = 4'b1010; rtc = 1'b1;
    enter(1'b1, 1'b1);
    keep = 4'b0000;
    chk("R4 mode", mode, 3);
    chk("R4 enables", en4(), 4'b0001);
    chk("R8 captured", ret, 4'b1010);
    chk("R12 rtc on in deep", rtc_en, 1);
    rtc = 1'b0; #1;
    chk("R12 rtc off", rtc_en, 0);
    irq = 8'h10; tick(); irq = '0;
    chk("R7 irq4 ignored", mode, 3);
    intr = 1'b1; berr = 1'b1; tick(); intr = 1'b0; berr = 1'b0;
    chk("R7 int/buserr ignored", mode, 3);
    irq = 8'h02; tick(); irq = '0;
    chk("R9 power step", en4(), 4'b0011);
    chk("R7 flag", wrst, 1);
    chk("R8 ret held", ret, 4'b1010);
    tick();
    chk("R9 cpg step", en4(), 4'b0111);
    tick(3);
    chk("R9 cpg hold", cpu_en, 0);
    tick();
    chk("R9 done", {cpu_en, done, ret}, {2'b11, 4'b1010});
    tick();
    chk("R8 run ret clear", {mode, done, ret}, 0);
  endtask

  task automatic t_deep_por;
    keep = 4'b1111;
    enter(1'b1, 1'b1);
    chk("R8 keep all", ret, 4'hF);
    por = 1'b1; tick(); por = 1'b0;
    chk("R8 por drops retention", ret, 0);
    chk("R7 por flag", {wrst, pwr_en, cpg_en}, 3'b110);
    tick(5);
    chk("R9 por wake done", done, 1);
    tick();
  endtask

  task automatic t_mstop;
    md = 8'hF3; mwe = 1'b1; tick(); mwe = 1'b0;
    chk("R10 stop applied", per_en, 8'h0C);
    enter(1'b0, 1'b0);
    chk("R10 stop in sleep", per_en, 8'h0C);
    intr = 1'b1; tick(); intr = 1'b0; tick();
    md = 8'hF1; mwe = 1'b1; tick(); mwe = 1'b0;
    chk("R10 resume bit1", per_en, 8'h0E);
    por = 1'b1; tick(); por = 1'b0;
    chk("R11 por partial clear", {mode, per_en}, {2'b00, 8'h0F});
    md = 8'hFF; mwe = 1'b1; por = 1'b1; tick(); mwe = 1'b0; por = 1'b0;
    chk("R11 por with write", per_en, 8'h0F);
    md = 8'h00; mwe = 1'b1; tick(); mwe = 1'b0;
  endtask

  task automatic t_pending;
    nmi = 1'b1; stby = 1'b1; deep = 1'b0; sleep = 1'b1; tick(); sleep = 1'b0; nmi = 1'b0;
    chk("R13 standby strobe ignored", {mode, en4()}, {2'b00, 4'b1110});
    intr = 1'b1; stby = 1'b0; sleep = 1'b1; tick(); sleep = 1'b0; intr = 1'b0;
    chk("R13 sleep strobe ignored", {mode, cpu_en}, {2'b00, 1'b1});
    irq = 8'h20; stby = 1'b1; deep = 1'b1; sleep = 1'b1; tick(); sleep = 1'b0; irq = '0;
    chk("R13 non-deep irq not pending", mode, 3);
    mrst = 1'b1; tick(); mrst = 1'b0;
    chk("R7 mrst deep wake", {wrst, pwr_en}, 2'b11);
    tick(6);
    chk("R9 run again", {mode, cpu_en}, {2'b00, 1'b1});
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_sleep();
    t_sstby();
    t_deep();
    t_deep_por();
    t_mstop();
    t_pending();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule